// File: doc/BRIEF.md
# Pixel Stipple and Run Blit Engine

This block owns a small frame memory of 8-bit pixels and edits it in response to 32-bit command writes. Each command carries a kind code, a bus address and a data word. The destination pixel is not in the data word. It is taken from the bus address: bits 22:3 form a 20-bit pixel index, and that index is reduced modulo the memory size. The fill colour comes from a separate colour command.

A stipple command uses its data word as a 32-bit pattern over 32 consecutive pixels. Pixels whose bit is set receive the fill colour, and the others keep their value. A blit command moves a run of 1 to 32 pixels. The data word gives the source index and the run length. A source field of all ones turns the blit into a fill with the fill colour. Any other source value gives an ascending copy from source to destination. A stall-free read port lets a host peek at any pixel.

The engine is a four-state machine:
- `S_IDLE` accepts commands.
- `S_STIP` walks a stipple pattern.
- `S_FILL` writes a fill run.
- `S_COPY` copies a run.

The machine moves from `S_IDLE` to one of the three run states when it accepts a stipple or blit command. It stays in that state and advances one pixel per clock. When the last pixel of the run is written it returns to `S_IDLE`. Colour and no-op commands are accepted in `S_IDLE` and leave the machine in `S_IDLE`.

Top module: `pix_stipple_blit`

## Requirements
- R1: After reset `cmd_ready` is 1 and `busy` is 0.
- R2: The destination pixel index is `cmd_addr[22:3]` reduced modulo 2^PIX_AW. Address bits 2:0 and 31:23 have no effect on which pixels change.
- R3: Stipple (kind 1) maps data bit 31 to destination+0 and data bit 0 to destination+31. A set bit writes the fill colour and a clear bit leaves the pixel unchanged.
- R4: Blit (kind 2) writes exactly `cmd_data[28:24]`+1 pixels starting at the destination. Data bits 31:29 have no effect.
- R5: A blit whose `cmd_data[23:0]` equals 24'hFFFFFF fills the run with the fill colour. Any other value, including one whose low PIX_AW bits are all ones, is a copy from source index `cmd_data[23:0]` modulo 2^PIX_AW.
- R6: A copy moves pixels in ascending order, one pixel per step. With the destination one above the source, the first source pixel is therefore replicated across the whole run.
- R7: An accepted stipple or blit raises `busy` for exactly as many cycles as pixels in the run (32 for a stipple). `cmd_ready` is 0 while `busy` is 1, and a command held on the inputs meanwhile waits without effect.
- R8: A colour command (kind 0) loads `cmd_data[7:0]` as the fill colour for later commands. Kind 3 changes nothing.
- R9: Run addresses for both destination and source wrap modulo 2^PIX_AW.
- R10: `peek_data` shows the pixel at `peek_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted on this edge when valid |
| cmd_kind | input | 2 | 0 colour, 1 stipple, 2 blit, 3 no-op |
| cmd_addr | input | 32 | Bus address; bits 22:3 select the destination pixel |
| cmd_data | input | 32 | Command data word |
| busy | output | 1 | A run is being written |
| peek_addr | input | PIX_AW | Pixel index to observe |
| peek_data | output | 8 | Registered pixel value |

## Verification
The bench targets several corner cases, and each one exposes a specific fault:
- Stipple patterns with both end bits set. A reversed bit order would paint the wrong end of the span.
- A copy whose source field has all low bits set, which a design comparing too few source bits would turn into a fill.
- An overlapping copy with the destination one above the source. A design that buffers the run instead of copying in ascending order would fail to replicate the first pixel.
- Runs that cross the top of memory and wrap.
- Busy lengths at 1, 7 and 32 pixels, which show an off-by-one in the length field.
- A colour command held during a run, which shows whether a stalled command leaks into the fill in progress.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

    typedef enum logic [1:0] {
        K_COLOUR  = 2'd0,
        K_STIPPLE = 2'd1,
        K_BLIT    = 2'd2,
        K_NOP     = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_STIP = 2'd1,
        S_FILL = 2'd2,
        S_COPY = 2'd3
    } run_state_e;

    localparam int unsigned DST_W    = 20;
    localparam int unsigned SRC_W    = 24;
    localparam int unsigned LEN_W    = 5;
    localparam logic [SRC_W-1:0] FILL_SRC = '1;

    typedef struct packed {
        run_state_e       op;
        logic [DST_W-1:0] dst;
        logic [SRC_W-1:0] src;
        logic [LEN_W-1:0] len_m1;
        logic [31:0]      mask;
    } run_desc_t;

endpackage

// File: rtl/sbe_decode.sv
module sbe_decode
    import sbe_pkg::*;
(
    input  logic [1:0]  kind,
    input  logic [31:0] addr,
    input  logic [31:0] data,
    output run_desc_t   desc,
    output logic        is_run,
    output logic        is_colour
);

    always_comb begin
        desc.dst    = addr[DST_W+2:3];
        desc.src    = data[SRC_W-1:0];
        desc.len_m1 = data[SRC_W+LEN_W-1:SRC_W];
        desc.mask   = data;
        desc.op     = S_IDLE;
        is_run      = 1'b0;
        is_colour   = 1'b0;
        unique case (cmd_kind_e'(kind))
            K_COLOUR: is_colour = 1'b1;
            K_STIPPLE: begin
                desc.op     = S_STIP;
                desc.len_m1 = '1;
                is_run      = 1'b1;
            end
            K_BLIT: begin
                desc.op = (data[SRC_W-1:0] == FILL_SRC) ? S_FILL : S_COPY;
                is_run  = 1'b1;
            end
            K_NOP: ;
        endcase
    end

endmodule

// File: rtl/sbe_pixmem.sv
module sbe_pixmem #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] src_addr,
    output logic [7:0]    src_data,
    input  logic [AW-1:0] peek_addr,
    output logic [7:0]    peek_data
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        peek_data <= mem[peek_addr];
    end

    assign src_data = mem[src_addr];

endmodule

// File: rtl/sbe_run_fsm.sv
module sbe_run_fsm
    import sbe_pkg::*;
#(
    parameter int unsigned PIX_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  run_desc_t         desc,
    input  logic [7:0]        colour,
    input  logic [7:0]        src_pix,
    output logic              busy,
    output logic              wr_en,
    output logic [PIX_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [PIX_AW-1:0] src_addr
);

    localparam logic [LEN_W-1:0] TOP_BIT = '1;

    run_state_e        state_q;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;
    logic [PIX_AW-1:0] dst_q;
    logic [PIX_AW-1:0] src_q;
    logic [31:0]       mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
            dst_q   <= '0;
            src_q   <= '0;
            mask_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        state_q <= desc.op;
                        idx_q   <= '0;
                        len_q   <= desc.len_m1;
                        dst_q   <= desc.dst[PIX_AW-1:0];
                        src_q   <= desc.src[PIX_AW-1:0];
                        mask_q  <= desc.mask;
                    end
                end
                S_STIP, S_FILL, S_COPY: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == len_q) state_q <= S_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        busy     = (state_q != S_IDLE);
        wr_addr  = dst_q + PIX_AW'(idx_q);
        src_addr = src_q + PIX_AW'(idx_q);
        wr_en    = 1'b0;
        wr_data  = colour;
        unique case (state_q)
            S_IDLE: wr_en = 1'b0;
            S_STIP: wr_en = mask_q[TOP_BIT - idx_q];
            S_FILL: wr_en = 1'b1;
            S_COPY: begin
                wr_en   = 1'b1;
                wr_data = src_pix;
            end
        endcase
    end

    a_r7_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state_q == S_IDLE);

    a_r4_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && $past(state_q) == S_FILL)
        |-> wr_addr == $past(wr_addr) + PIX_AW'(1));

    a_r6_copy_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COPY && $past(state_q) == S_COPY)
        |-> src_addr == $past(src_addr) + PIX_AW'(1));

    a_r3_stip_span: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STIP && $past(state_q) == S_STIP)
        |-> wr_addr == $past(wr_addr) + PIX_AW'(1));

endmodule

// File: rtl/pix_stipple_blit.sv
module pix_stipple_blit
    import sbe_pkg::*;
#(
    parameter int unsigned PIX_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_kind,
    input  logic [31:0]       cmd_addr,
    input  logic [31:0]       cmd_data,
    output logic              busy,
    input  logic [PIX_AW-1:0] peek_addr,
    output logic [7:0]        peek_data
);

    run_desc_t         desc;
    logic              is_run;
    logic              is_colour;
    logic              accept;
    logic [7:0]        colour_q;
    logic              wr_en;
    logic [PIX_AW-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [PIX_AW-1:0] src_addr;
    logic [7:0]        src_pix;

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;

    sbe_decode u_dec (
        .kind      (cmd_kind),
        .addr      (cmd_addr),
        .data      (cmd_data),
        .desc      (desc),
        .is_run    (is_run),
        .is_colour (is_colour)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                    colour_q <= '0;
        else if (accept && is_colour)  colour_q <= cmd_data[7:0];
    end

    sbe_run_fsm #(.PIX_AW(PIX_AW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && is_run),
        .desc     (desc),
        .colour   (colour_q),
        .src_pix  (src_pix),
        .busy     (busy),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .src_addr (src_addr)
    );

    sbe_pixmem #(.AW(PIX_AW)) u_mem (
        .clk       (clk),
        .we        (wr_en),
        .waddr     (wr_addr),
        .wdata     (wr_data),
        .src_addr  (src_addr),
        .src_data  (src_pix),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    a_r7_busy_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_run) |=> busy);

    a_r8_colour_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(colour_q));

    a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !wr_en);

endmodule

// File: tb/sim_pix_stipple_blit.sv
module sim_pix_stipple_blit;

    localparam int unsigned AW = 8;
    localparam int unsigned N  = 1 << AW;

    typedef struct {
        int         addr;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_kind = 2'd3;
    logic [31:0]   cmd_addr = '0;
    logic [31:0]   cmd_data = '0;
    logic          busy;
    logic [AW-1:0] peek_addr = '0;
    logic [7:0]    peek_data;

    int applied = 0;
    int miscmp  = 0;

    logic [7:0] ref_mem [N];
    logic [7:0] ref_col = 8'h00;
    item_t      sb_q [$];

    always #10 clk = ~clk;

    pix_stipple_blit #(.PIX_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .busy(busy), .peek_addr(peek_addr), .peek_data(peek_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        applied++;
        if (!ok) begin
            miscmp++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // reference model of one command
    task automatic model(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
        logic [AW-1:0] dst;
        logic [AW-1:0] src;
        int            len;
        dst = a[AW+2:3];
        src = d[AW-1:0];
        len = int'(d[28:24]) + 1;
        case (k)
            2'd0: ref_col = d[7:0];
            2'd1: for (int i = 0; i < 32; i++)
                      if (d[31-i]) ref_mem[AW'(dst + AW'(i))] = ref_col;
            2'd2: begin
                if (d[23:0] == 24'hFFFFFF)
                    for (int i = 0; i < len; i++) ref_mem[AW'(dst + AW'(i))] = ref_col;
                else
                    for (int i = 0; i < len; i++)
                        ref_mem[AW'(dst + AW'(i))] = ref_mem[AW'(src + AW'(i))];
            end
            default: ;
        endcase
    endtask

    task automatic issue(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
        int exp_len;
        int cnt;
        model(k, a, d);
        exp_len = (k == 2'd1) ? 32 : (k == 2'd2) ? int'(d[28:24]) + 1 : 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_data = d;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = 2'd3;
        if (exp_len > 0) check(cmd_ready == 1'b0, "R7 ready low in run", int'(cmd_ready), 0);
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == exp_len, "R7 busy cycles", cnt, exp_len);
    endtask

    task automatic check_all(input string tag);
        for (int p = 0; p < N; p++) begin
            @(negedge clk);
            peek_addr = AW'(p);
            sb_q.push_back('{addr: p, exp: ref_mem[p], tag: tag});
        end
        repeat (3) @(negedge clk);
    endtask

    // monitor: compares the item pushed one cycle earlier
    initial begin
        item_t held;
        bit    have;
        have = 1'b0;
        forever begin
            @(negedge clk);
            #2;
            if (have) begin
                applied++;
                if (peek_data !== held.exp) begin
                    miscmp++;
                    $display("FAIL %s R10 pixel %0d actual %02h expected %02h",
                             held.tag, held.addr, peek_data, held.exp);
                end
            end
            if (sb_q.size() > 0) begin
                held = sb_q.pop_front();
                have = 1'b1;
            end else begin
                have = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscmp++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
        $finish;
    end

    initial begin
        int stall;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1 ready after reset", int'(cmd_ready), 1);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

        // R4 R5 R8: initialise memory with per-block fill colours
        for (int b = 0; b < N / 32; b++) begin
            issue(2'd0, 32'h0, 32'h0000_0010 + 32'(b * 17));
            issue(2'd2, 32'(b * 32) << 3, 32'h1FFF_FFFF);
        end
        check_all("R5 fill init");

        // R2 R3: stipple with noisy address bits
        issue(2'd0, 32'h0, 32'h0000_00E7);
        issue(2'd1, 32'hFF80_0000 | (32'd40 << 3) | 32'h7, 32'h8000_0001);
        issue(2'd0, 32'h0, 32'h0000_005A);
        issue(2'd1, (32'd100 << 3) | 32'h5, 32'hA5C3_0F01);
        check_all("R3 stipple");

        // R4 R5 R6: copies of length 1, 7, 32, ignored high bits, near-sentinel source
        issue(2'd2, 32'd200 << 3, 32'h0000_0028);
        issue(2'd2, 32'd10 << 3,  32'hE600_0064);
        issue(2'd2, 32'd130 << 3, 32'h1F00_0060);
        issue(2'd2, 32'd180 << 3, 32'h0300_00FF);
        check_all("R5 copy");

        // R6 overlap, R9 wrap on destination and source
        issue(2'd2, 32'd61 << 3, 32'h0900_003C);
        issue(2'd2, 32'd250 << 3, 32'h0900_0028);
        issue(2'd2, 32'd20 << 3, 32'h0B00_00FA);
        check_all("R9 wrap R6 overlap");

        // R8: kind 3 has no effect
        issue(2'd3, 32'd0, 32'hFFFF_FFFF);
        issue(2'd1, 32'd0, 32'h0000_0000);
        check_all("R8 nop");

        // R7: colour command held while a fill runs must not colour that fill
        issue(2'd0, 32'h0, 32'h0000_0033);
        model(2'd2, 32'd140 << 3, 32'h0FFF_FFFF);
        model(2'd0, 32'h0, 32'h0000_00C4);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'd2; cmd_addr = 32'd140 << 3; cmd_data = 32'h0FFF_FFFF;
        @(negedge clk);
        cmd_kind = 2'd0; cmd_data = 32'h0000_00C4;
        stall = 0;
        while (!cmd_ready && stall < 100) begin
            stall++;
            @(negedge clk);
        end
        check(stall == 16, "R7 stalled colour wait", stall, 16);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = 2'd3;
        issue(2'd1, 32'd0, 32'hF000_0000);
        check_all("R7 R8 held colour");

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
        $finish;
    end

endmodule